// File: doc/BRIEF.md
# Dual-Client Guarded FIFO

This block is a synchronous first-in first-out queue that two independent callers share. Each of its three operations has a guarded handshake: push, pop and peek at the oldest word. The queue raises a ready line from its own state. A caller asserts an enable only while that ready line is high. An enable that arrives without its ready line is treated as a protocol violation and has no effect.

Each client has its own push and pop ports. A fixed-priority arbiter sits on the push side and another sits on the pop side. Client 0 always wins over client 1. A client that loses sees its ready line drop for that cycle, so at most one push and one pop are accepted per cycle and the callers never have to coordinate with each other. The peek path does not change state, so every client sees the oldest word at the same time.

Occupancy is held in a count register. Full and empty are decoded from that count. A push and a pop in the same cycle are both accepted when the queue is neither full nor empty. The queue has no bypass path: a word pushed in one cycle can be popped in the next cycle at the earliest.

Top module: `gfq_dual_client`

## Requirements
- R1: After reset the queue is empty: every enq_rdy is 1, and every deq_rdy and first_rdy is 0.
- R2: enq_rdy is 0 for every client while the queue holds DEPTH entries (default 4). After DEPTH accepted pushes with no pop, no further push is accepted until a pop occurs.
- R3: deq_rdy and first_rdy are 0 for every client while the queue is empty, and are 1 (subject to R6 for deq_rdy) while it holds at least one entry.
- R4: first_data shows the oldest stored word whenever first_rdy is 1. Words leave in the order they were accepted. Every client's first_data slice (bits [i*DATA_W +: DATA_W]) carries the same word.
- R5: At most one push and at most one pop are accepted per cycle. When both clients push together, only one word is stored.
- R6: Client 0 has priority over client 1 on each side. While enq_en[0] is 1, enq_rdy[1] is 0. While deq_en[0] is 1, deq_rdy[1] is 0. When both push together, client 0's word is the one stored.
- R7: An enable asserted while its ready is 0 is ignored. A push at full and a pop at empty leave the occupancy and the stored words unchanged.
- R8: A push and a pop in the same cycle, with the queue neither full nor empty, are both performed and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_en | input | N_CLI | Push enable, one bit per client |
| enq_data | input | N_CLI*DATA_W | Push word per client, client i in bits [i*DATA_W +: DATA_W] |
| enq_rdy | output | N_CLI | Push ready, one bit per client |
| deq_en | input | N_CLI | Pop enable, one bit per client |
| deq_rdy | output | N_CLI | Pop ready, one bit per client |
| first_rdy | output | N_CLI | Oldest-word valid, one bit per client |
| first_data | output | N_CLI*DATA_W | Oldest word, same value in each client slice |

## Verification
Directed sequences come first. They push from both clients at once to separate arbitration from storage. They fill the queue to full and then assert further enables, which tells a proper guard apart from a count that wraps or a word that gets overwritten. A pop at empty and a push-plus-pop in the middle of the occupancy range show whether the count update handles each combination of operations. A long random phase follows. In it, clients assert enables with no regard to their ready lines, which mixes legal operations with protocol violations at every occupancy level. A queue model in the bench predicts every ready line and the head word in each cycle.

// File: rtl/gfq_pkg.sv
package gfq_pkg;
  // Operation seen by the storage in one cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

  function automatic fifo_op_e op_of(input logic push, input logic pop);
    return fifo_op_e'({pop, push});
  endfunction
endpackage

// File: rtl/gfq_prio_arb.sv
module gfq_prio_arb #(
  parameter int N_CLI = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             avail,
  input  logic [N_CLI-1:0] req,
  output logic [N_CLI-1:0] rdy,
  output logic [N_CLI-1:0] gnt
);
  // Lower index wins; a requester blocks every higher index
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    for (int i = 0; i < N_CLI; i++) begin
      rdy[i]  = avail && !blocked;
      blocked = blocked | req[i];
    end
  end

  assign gnt = req & rdy;

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R7
  gnt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |-> (gnt == '0));

  generate
    for (genvar g = 1; g < N_CLI; g++) begin : g_prio
      // R6
      prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy[g] |-> (req[g-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/gfq_store.sv
module gfq_store
  import gfq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_word,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [DATA_W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  fifo_op_e          op;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                  input fifo_op_e o);
    case (o)
      OP_PUSH: return c + CNT_W'(1);
      OP_POP:  return c - CNT_W'(1);
      default: return c;
    endcase
  endfunction

  assign op    = op_of(push, pop);
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_step(wr_ptr);
      if (pop)  rd_ptr <= ptr_step(rd_ptr);
      count <= count_next(count, op);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_word;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BOTH) |=> (count == $past(count)));
endmodule

// File: rtl/gfq_dual_client.sv
module gfq_dual_client #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int N_CLI  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CLI-1:0]        enq_en,
  input  logic [N_CLI*DATA_W-1:0] enq_data,
  output logic [N_CLI-1:0]        enq_rdy,
  input  logic [N_CLI-1:0]        deq_en,
  output logic [N_CLI-1:0]        deq_rdy,
  output logic [N_CLI-1:0]        first_rdy,
  output logic [N_CLI*DATA_W-1:0] first_data
);
  logic              full, empty;
  logic [N_CLI-1:0]  enq_gnt, deq_gnt;
  logic              push_fire, pop_fire;
  logic [DATA_W-1:0] push_word, head;

  gfq_prio_arb #(.N_CLI(N_CLI)) u_enq_arb (
    .clk(clk), .rst_n(rst_n), .avail(!full),
    .req(enq_en), .rdy(enq_rdy), .gnt(enq_gnt)
  );

  gfq_prio_arb #(.N_CLI(N_CLI)) u_deq_arb (
    .clk(clk), .rst_n(rst_n), .avail(!empty),
    .req(deq_en), .rdy(deq_rdy), .gnt(deq_gnt)
  );

  assign push_fire = |enq_gnt;
  assign pop_fire  = |deq_gnt;

  // Word of the granted client (grant is one-hot or zero)
  always_comb begin
    push_word = '0;
    for (int i = 0; i < N_CLI; i++)
      if (enq_gnt[i]) push_word = enq_data[i*DATA_W +: DATA_W];
  end

  gfq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push_fire), .push_word(push_word), .pop(pop_fire),
    .full(full), .empty(empty), .head(head)
  );

  generate
    for (genvar g = 0; g < N_CLI; g++) begin : g_peek
      assign first_rdy[g] = !empty;
      assign first_data[g*DATA_W +: DATA_W] = head;
    end
  endgenerate

  // R3
  peek_vs_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_rdy[0] |-> first_rdy[0]);

  // R7
  push_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> |(enq_en & enq_rdy));
endmodule

// File: tb/gfq_dual_client_tb.sv
module gfq_dual_client_tb;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   enq_en = '0;
  logic [2*W-1:0] enq_data = '0;
  logic [1:0]   enq_rdy;
  logic [1:0]   deq_en = '0;
  logic [1:0]   deq_rdy;
  logic [1:0]   first_rdy;
  logic [2*W-1:0] first_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [W-1:0] mq[$];

  always #4 clk = ~clk;

  gfq_dual_client #(.DATA_W(W), .DEPTH(D), .N_CLI(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .enq_en(enq_en), .enq_data(enq_data),
    .enq_rdy(enq_rdy), .deq_en(deq_en), .deq_rdy(deq_rdy),
    .first_rdy(first_rdy), .first_data(first_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit exp_enq_rdy(input int idx, input logic [1:0] ee, input int sz);
    return (sz < D) && (idx == 0 || !ee[0]);
  endfunction

  function automatic bit exp_deq_rdy(input int idx, input logic [1:0] de, input int sz);
    return (sz > 0) && (idx == 0 || !de[0]);
  endfunction

  // Drive one cycle, check outputs against the model, then advance the model
  task automatic step(input logic [1:0] ee, input logic [W-1:0] d0,
                      input logic [W-1:0] d1, input logic [1:0] de);
    int sz;
    bit do_pop;
    @(negedge clk);
    enq_en = ee; enq_data = {d1, d0}; deq_en = de;
    #1;
    sz = mq.size();
    for (int i = 0; i < 2; i++) begin
      chk(enq_rdy[i] == exp_enq_rdy(i, ee, sz), (i == 0) ? "R2 enq_rdy" : "R6 enq_rdy",
          32'(enq_rdy[i]), 32'(exp_enq_rdy(i, ee, sz)));
      chk(deq_rdy[i] == exp_deq_rdy(i, de, sz), (i == 0) ? "R3 deq_rdy" : "R6 deq_rdy",
          32'(deq_rdy[i]), 32'(exp_deq_rdy(i, de, sz)));
      chk(first_rdy[i] == (sz > 0), "R3 first_rdy", 32'(first_rdy[i]), 32'(sz > 0));
      if (sz > 0)
        chk(first_data[i*W +: W] == mq[0], "R4 first_data",
            32'(first_data[i*W +: W]), 32'(mq[0]));
    end
    do_pop = (sz > 0) && (de != 2'b00);
    if (sz < D) begin
      if (ee[0])      mq.push_back(d0);
      else if (ee[1]) mq.push_back(d1);
    end
    if (do_pop) void'(mq.pop_front());
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(enq_rdy == 2'b11, "R1 enq_rdy", 32'(enq_rdy), 32'h3);
    chk(deq_rdy == 2'b00, "R1 deq_rdy", 32'(deq_rdy), 32'h0);
    chk(first_rdy == 2'b00, "R1 first_rdy", 32'(first_rdy), 32'h0);

    // R5/R6: both push together; only client 0's word stored
    step(2'b11, 8'hA0, 8'hB1, 2'b00);
    step(2'b00, 8'h00, 8'h00, 2'b00);
    chk(first_data[W-1:0] == 8'hA0, "R6 winner word", 32'(first_data[W-1:0]), 32'hA0);
    step(2'b00, 8'h00, 8'h00, 2'b10);
    step(2'b00, 8'h00, 8'h00, 2'b00);
    chk(deq_rdy == 2'b00, "R5 single push stored", 32'(deq_rdy), 32'h0);

    // R7: pop at empty ignored
    step(2'b00, 8'h00, 8'h00, 2'b11);
    step(2'b10, 8'h00, 8'h5C, 2'b00);
    step(2'b00, 8'h00, 8'h00, 2'b00);
    chk(first_data[2*W-1:W] == 8'h5C, "R7 pop at empty ignored",
        32'(first_data[2*W-1:W]), 32'h5C);

    // R2: fill to full from client 1
    for (int k = 0; k < D - 1; k++) step(2'b10, 8'h00, 8'(8'h10 + k), 2'b00);
    step(2'b00, 8'h00, 8'h00, 2'b00);
    chk(enq_rdy == 2'b00, "R2 full blocks push", 32'(enq_rdy), 32'h0);
    chk(deq_rdy[0] == 1'b1, "R2 pop allowed at full", 32'(deq_rdy[0]), 32'h1);
    // R7: push at full from both clients ignored
    step(2'b11, 8'hEE, 8'hFF, 2'b00);
    step(2'b00, 8'h00, 8'h00, 2'b00);
    chk(first_data[W-1:0] == 8'h5C, "R7 push at full ignored",
        32'(first_data[W-1:0]), 32'h5C);
    // drain two, leaving two entries
    step(2'b00, 8'h00, 8'h00, 2'b01);
    step(2'b00, 8'h00, 8'h00, 2'b10);
    // R8: push and pop together at occupancy 2
    step(2'b01, 8'h77, 8'h00, 2'b01);
    step(2'b00, 8'h00, 8'h00, 2'b01);
    step(2'b00, 8'h00, 8'h00, 2'b01);
    step(2'b00, 8'h00, 8'h00, 2'b00);
    chk(deq_rdy == 2'b00, "R8 occupancy held", 32'(deq_rdy), 32'h0);

    // Random phase: enables asserted regardless of ready
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] ee, de;
      ee = 2'($urandom_range(0, 3));
      de = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) ee = 2'b00;
      if ($urandom_range(0, 3) == 0) de = 2'b00;
      step(ee, 8'($urandom), 8'($urandom), de);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule